// File: doc/BRIEF.md
# Edge-Started Conversion Sequencer for an ADC

This block sequences an analog-to-digital converter whose conversions begin on an external trigger. A host writes a small mode word. It holds a trigger-enable flag, a two-bit mode field and a channel number. When trigger-enable is set and the mode field is non-zero, the sequencer parks in a standby state and waits for a rising edge on an asynchronous trigger pin. After that edge it drives the analog multiplexer to the chosen channel and converts that channel over and over, with no gap between conversions. Each result goes into the result register that belongs to the channel, and a one-cycle end-of-conversion interrupt is raised for each result.

The analog converter is modelled as a fixed-length conversion window of `CONV_CYCLES` clocks. At the end of the window the sample input is captured. A new trigger edge during a conversion throws that conversion away and starts a fresh one. A host write throws it away too, and sends the sequencer back to standby with the new settings, or to idle if the new settings do not enable the trigger.

The controller has three states. **IDLE** means hardware start is disabled. **STANDBY** means it is armed and waiting for an edge. **CONVERT** means a conversion window is running. The transitions are:
- WRITE_ARM: any state to STANDBY, on a write that enables hardware start.
- WRITE_DISARM: any state to IDLE, on a write that does not enable it.
- FIRE: STANDBY to CONVERT, on an edge.
- RESTART: CONVERT to CONVERT with the window reset, on an edge.
- CHAIN: CONVERT to CONVERT, on completion, when the next window begins at once.
- HOLD: each state holds otherwise.

Top module: `adc_hwtrig_seq`

## Requirements
- R1: While reset is held and right after it, conv_busy, standby, eoc_irq and mux_sel are 0 and every result register reads 0.
- R2: A cycle with cfg_we=1 loads cfg_wdata (bits [2:0] channel, bits [4:3] mode, bit 5 trigger-enable). The next cycle shows standby=1 if bit 5 is 1 and bits [4:3] are not 00. Otherwise it shows idle (standby=0, conv_busy=0).
- R3: In idle, trigger edges are ignored: conv_busy and standby stay 0 and no interrupt occurs.
- R4: trig_in passes through two synchronizing flops, and a valid edge is a 0-to-1 change of the synchronized value. A rising trig_in first sampled at clock edge k makes a STANDBY sequencer show conv_busy=1 after clock edge k+2.
- R5: A conversion lasts CONV_CYCLES clocks. On its last clock eoc_irq is 1 for exactly that clock, and sample_in is written into the result register of the current channel.
- R6: After a completed conversion the next one starts on the following clock without another trigger, so eoc_irq repeats every CONV_CYCLES clocks.
- R7: A valid edge during CONVERT, including on the last clock, abandons the running conversion without an interrupt or result write, and a new full-length conversion begins.
- R8: A write during CONVERT abandons the conversion without an interrupt or result write, and applies the new settings, including a new channel, from the next cycle.
- R9: When a write and a valid edge reach the controller in the same cycle, the write wins and the edge is dropped.
- R10: mux_sel always shows the loaded channel. rd_data shows the result register selected by rd_sel, and registers of other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 6 | Mode word: [5] trigger-enable, [4:3] mode, [2:0] channel |
| trig_in | input | 1 | Asynchronous external trigger |
| sample_in | input | SAMPLE_W | Converter output sample |
| rd_sel | input | 3 | Result register read select |
| conv_busy | output | 1 | A conversion window is running |
| standby | output | 1 | Armed, waiting for a trigger edge |
| mux_sel | output | 3 | Analog channel select |
| eoc_irq | output | 1 | End-of-conversion pulse |
| rd_data | output | SAMPLE_W | Selected result register |

## Verification
A wrong internal state shows at the ports within one clock. A stuck or misrouted state shows at once on conv_busy and standby. A conversion counter that is off by one moves eoc_irq, so an interrupt comes early, comes late or is missing within one conversion window. A lost restart shows up as an interrupt from a conversion that should have been abandoned. A wrong channel latch shows on mux_sel immediately, and on rd_data once the next result is written. The reference model tracks all of these outputs on every clock through retriggers, rewrites and coincident write/edge cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W = 3;
    localparam int NUM_CH = 1 << CHAN_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STANDBY = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              trig_en;
        logic [1:0]        mode;
        logic [CHAN_W-1:0] chan;
    } mode_word_t;

    function automatic logic hw_start_ok(input mode_word_t m);
        return m.trig_en & (|m.mode);
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   delay_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            delay_q <= 1'b0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], trig_async};
            delay_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign trig_edge = sync_q[SYNC_STAGES-1] & ~delay_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_CYCLES = 16,
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(CONV_CYCLES - 1);

    assign last = (cnt == LAST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int SAMPLE_W = 10,
    parameter int NUM_CH   = 8,
    localparam int SEL_W   = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic [SAMPLE_W-1:0] slot_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_sel];
endmodule

// File: rtl/adc_hwtrig_seq.sv
module adc_hwtrig_seq
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int CONV_CYCLES = 16,
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [5:0]          cfg_wdata,
    input  logic                trig_in,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [2:0]          rd_sel,
    output logic                conv_busy,
    output logic                standby,
    output logic [2:0]          mux_sel,
    output logic                eoc_irq,
    output logic [SAMPLE_W-1:0] rd_data
);
    seq_state_e        state_q, state_d;
    mode_word_t        cfg_q, cfg_new;
    logic              trig_edge;
    logic              timer_clear, timer_run, timer_last;
    logic [CNT_W-1:0]  conv_cnt;
    logic              conv_done;

    assign cfg_new = mode_word_t'(cfg_wdata);

    // mode word holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_new;
    end

    adc_trig_sync #(.SYNC_STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .trig_edge  (trig_edge)
    );

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (timer_run),
        .cnt   (conv_cnt),
        .last  (timer_last)
    );

    adc_result_bank #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (conv_done),
        .wr_sel  (cfg_q.chan),
        .wr_data (sample_in),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: a write outranks a trigger edge
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = hw_start_ok(cfg_new) ? ST_STANDBY : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_STANDBY: state_d = trig_edge ? ST_CONVERT : ST_STANDBY;
                ST_CONVERT: state_d = ST_CONVERT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath controls
    always_comb begin
        conv_busy   = 1'b0;
        standby     = 1'b0;
        conv_done   = 1'b0;
        timer_run   = 1'b0;
        timer_clear = cfg_we;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_STANDBY: begin
                standby = 1'b1;
                if (trig_edge) timer_clear = 1'b1;
            end
            ST_CONVERT: begin
                conv_busy = 1'b1;
                timer_run = 1'b1;
                if (trig_edge) timer_clear = 1'b1;
                conv_done = timer_last & ~trig_edge & ~cfg_we;
            end
            default: begin
            end
        endcase
    end

    assign eoc_irq = conv_done;
    assign mux_sel = cfg_q.chan;
endmodule

// File: rtl/adc_hwtrig_seq_chk.sv
module adc_hwtrig_seq_chk #(
    parameter int CONV_CYCLES = 16,
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [5:0]       cfg_wdata,
    input logic             trig_edge,
    input logic             conv_busy,
    input logic             standby,
    input logic             eoc_irq,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(CONV_CYCLES - 1);
    logic arm_wr;
    assign arm_wr = cfg_we & cfg_wdata[5] & (|cfg_wdata[4:3]);

    a_r2_arm_write: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (standby && !conv_busy));

    a_r2_disarm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !arm_wr) |=> (!standby && !conv_busy));

    a_r3_idle_ignores_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && !standby && !cfg_we) |=> (!conv_busy && !standby));

    a_r7_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && trig_edge && !cfg_we) |=> (conv_busy && cnt == '0));

    a_r6_chain_next: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && cnt == LAST_VAL && !trig_edge && !cfg_we) |=> (conv_busy && cnt == '0));

    a_r5_irq_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> (conv_busy && cnt == LAST_VAL));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && trig_edge) |-> !eoc_irq);
endmodule

bind adc_hwtrig_seq adc_hwtrig_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .trig_edge (trig_edge),
    .conv_busy (conv_busy),
    .standby   (standby),
    .eoc_irq   (eoc_irq),
    .cnt       (conv_cnt)
);

// File: tb/adc_hwtrig_seq_test.sv
`timescale 1ns/1ps
module adc_hwtrig_seq_test;
    localparam int SW = 10;
    localparam int N  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic          trig_in = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic [2:0]    rd_sel = '0;
    logic          conv_busy, standby, eoc_irq;
    logic [2:0]    mux_sel;
    logic [SW-1:0] rd_data;

    always #4 clk = ~clk;

    adc_hwtrig_seq #(.SAMPLE_W(SW), .CONV_CYCLES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .trig_in(trig_in), .sample_in(sample_in), .rd_sel(rd_sel),
        .conv_busy(conv_busy), .standby(standby), .mux_sel(mux_sel),
        .eoc_irq(eoc_irq), .rd_data(rd_data)
    );

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;
    string tag = "R1";

    // reference model state
    int m_st = 0, m_cnt = 0, m_chan = 0;
    int m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int m_res [8];
    int cyc = 0, dut_irqs = 0, mdl_irqs = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // one clock: compare outputs against model, then advance model
    task automatic tick();
        int edge_v, done_v, en_v;
        #1;
        edge_v = (m_s2 == 1 && m_s3 == 0);
        done_v = (m_st == 2 && m_cnt == N-1 && !edge_v && !cfg_we);
        check(tag, conv_busy, (m_st == 2), "conv_busy");
        check(tag, standby, (m_st == 1), "standby");
        check(tag, eoc_irq, done_v, "eoc_irq");
        check("R10", mux_sel, m_chan, "mux_sel");
        check("R10", rd_data, m_res[rd_sel], "rd_data");
        if (eoc_irq) dut_irqs++;
        if (done_v) mdl_irqs++;
        if (rst_n) begin
            if (cfg_we) begin
                m_chan = cfg_wdata[2:0];
                en_v = cfg_wdata[5] && (cfg_wdata[4:3] != 0);
                m_st = en_v ? 1 : 0;
                m_cnt = 0;
            end else if (m_st == 1 && edge_v) begin
                m_st = 2; m_cnt = 0;
            end else if (m_st == 2 && edge_v) begin
                m_cnt = 0;
            end else if (m_st == 2) begin
                if (done_v) m_res[m_chan] = sample_in;
                m_cnt = (m_cnt == N-1) ? 0 : m_cnt + 1;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in;
        end
        @(negedge clk);
        cyc++;
        sample_in = SW'((cyc * 37 + 5) % 1024);
        rd_sel = 3'(cyc % 8);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic en, input logic [1:0] md, input logic [2:0] ch);
        cfg_we = 1'b1; cfg_wdata = {en, md, ch};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int hi, input int lo);
        trig_in = 1'b1; run(hi);
        trig_in = 1'b0; run(lo);
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_res[i] = 0;
        @(negedge clk);
        tag = "R1"; run(3);
        rst_n = 1'b1;
        run(2);
        // R1: all result registers read back zero after reset
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i); #1;
            check("R1", rd_data, 0, "reset result");
        end

        // R3: disabled by trigger-enable=0, then by mode=00
        tag = "R3";
        wr(1'b0, 2'b11, 3'd2);
        pulse(3, 4); pulse(3, 20);
        wr(1'b1, 2'b00, 3'd4);
        pulse(3, 4); pulse(3, 20);
        check("R3", dut_irqs, 0, "irq count while idle");

        // R2: arm on channel 1
        tag = "R2";
        wr(1'b1, 2'b10, 3'd1);
        run(10);

        // R4/R5/R6: start and free-run
        tag = "R4";
        pulse(2, 6);
        tag = "R6";
        dut_irqs = 0; mdl_irqs = 0;
        run(3 * N + 5);
        check("R6", dut_irqs, mdl_irqs, "chained irq count");
        check("R6", (dut_irqs >= 3) ? 1 : 0, 1, "at least three chained results");

        // R7: retrigger mid-conversion and on the final cycle
        tag = "R7";
        run(5);
        pulse(2, 2 * N);
        for (int off = N - 4; off < N + 2; off++) begin
            pulse(1, off);
        end
        run(N);

        // R8: rewrite during conversion to channel 5, then restart
        tag = "R8";
        run(7);
        wr(1'b1, 2'b01, 3'd5);
        run(12);
        check("R8", standby, 1, "standby after rewrite");
        pulse(2, 2 * N + 4);
        run(3);
        wr(1'b0, 2'b10, 3'd3);
        run(N + 2);

        // R9: write arriving on the same cycle as a synchronized edge, several offsets
        tag = "R9";
        for (int off = 0; off < 5; off++) begin
            wr(1'b1, 2'b11, 3'(off + 2));
            pulse(2, N + 3);
            trig_in = 1'b1;
            run(off);
            wr(1'b1, 2'b10, 3'(7 - off));
            trig_in = 1'b0;
            run(N + 4);
        end

        // R5/R10: long run on two channels, all slots swept by rd_sel
        tag = "R5";
        wr(1'b1, 2'b11, 3'd6);
        pulse(2, 3 * N);
        tag = "R10";
        wr(1'b1, 2'b01, 3'd0);
        pulse(2, 3 * N);
        run(20);
        finish_up();
    end
endmodule